// File: doc/BRIEF.md
# Gaussian FSK Transmit Shaper

This block shapes the serial transmit bit stream before it reaches a frequency modulator. It runs on a filter clock that is twelve times the bit rate. On every filter clock it takes the present level of the serial data input as one sample, +1 for a high level and -1 for a low level. It convolves the most recent twelve samples with a fixed, symmetric set of Gaussian weights for a bandwidth-time product of 0.5. A deviation code then scales the filtered value, and the block drives the result as a signed frequency-deviation word.

The shaper runs only while its own enable is set and the transceiver reports transmit mode. When either of these is low, the sample history is emptied and the output word stays at zero. The next enable therefore starts from silence and not from stale samples. The deviation code picks one of eight gains between 60 % and 130 % of nominal. At 100 %, a long run of equal bits gives a word of plus or minus 1024, which corresponds to the nominal peak deviation.

Top module: `gfsk_tx_shaper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `dev_word` becomes 0 and the sample history is emptied.
- R2: While active, each rising edge shifts one sample into a 12-entry history (+1 for `tx_bit`=1, -1 for `tx_bit`=0; empty entries count 0). The weights are 8, 13, 19, 25, 30, 33, 33, 30, 25, 19, 13, 8, with the newest sample on the first weight. The weighted sum is registered one edge after sampling, and `dev_word` shows the scaled sum one edge after that, so a sample taken at edge n first shows at edge n+2.
- R3: Twelve or more equal samples at code 4 (100 %) give `dev_word` = +1024 for ones and -1024 for zeros.
- R4: `dev_code` c selects the gain round(128*(60+10c)/100), which is 77, 90, 102, 115, 128, 141, 154 or 166 in units of 1/128. A full run of ones then gives 616, 720, 816, 920, 1024, 1128, 1232 or 1328, and a full run of zeros gives the negated value.
- R5: `dev_word` = floor((sum*gain + 16)/32), which is round to nearest with ties toward plus infinity, clamped to the signed 12-bit range. For example, a lone first sample of 1 at code 1 gives 23, and a lone first sample of 0 gives -22.
- R6: With `shaper_en` low, the next edge sets `dev_word` to 0 and empties the history. After re-enable, the output rebuilds from an empty history.
- R7: With `tx_mode` low and `shaper_en` high, the block behaves exactly as in R6.
- R8: A change of `dev_code` changes `dev_word` at the very next edge and leaves the sample history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock, twelve per bit |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_bit | input | 1 | Serial transmit data, sampled every clock |
| shaper_en | input | 1 | Filter enable |
| tx_mode | input | 1 | High while the transceiver transmits |
| dev_code | input | 3 | Deviation scaling code, 60 %..130 % |
| dev_word | output | 12 | Signed frequency-deviation word |

## Verification
Long runs of equal bits at every deviation code set the steady gain and sign of each code apart. A lone first sample after an empty history exposes the pipeline depth, the leading weight and the tie-rounding direction. Bit patterns held for a whole bit period, alternating each sample, and pseudo-random are compared against a reference convolution on every cycle, which separates the weight order and the history shift. Dropping the enable or the transmit qualifier in the middle of a stream, then re-enabling with the opposite polarity, shows whether the history really was emptied.

// File: rtl/gfsk_pkg.sv
// Shared constants and functions for the Gaussian transmit shaper.
// Assumes a fixed 12-weight table for BT = 0.5 over one bit of 12 samples.
package gfsk_pkg;

    localparam int NTAPS     = 12;
    localparam int GAIN_FRAC = 7;   // gain unit is 1/128
    localparam int GAIN_W    = 8;

    // One history entry: vld=0 means empty (weight contributes 0)
    typedef struct packed {
        logic vld;
        logic neg;
    } smp_t;

    // Weight k of the symmetric Gaussian table (first half mirrored)
    function automatic int tap_coef(input int k);
        int m;
        m = (k < NTAPS / 2) ? k : (NTAPS - 1 - k);
        case (m)
            0:       return 8;
            1:       return 13;
            2:       return 19;
            3:       return 25;
            4:       return 30;
            default: return 33;
        endcase
    endfunction

    // Sum of all weights, the filter's DC gain
    function automatic int tap_total();
        int s;
        s = 0;
        for (int k = 0; k < NTAPS; k++) s += tap_coef(k);
        return s;
    endfunction

    // Gain for deviation code c: round(128*(60+10c)/100)
    function automatic int gain_q7(input int c);
        return ((1 << GAIN_FRAC) * (60 + 10 * c) + 50) / 100;
    endfunction

    localparam int TAP_SUM      = tap_total();
    localparam int TAP_SUM_LOG2 = $clog2(TAP_SUM);

endpackage

// File: rtl/gfsk_delay_line.sv
// Sample history of the shaper. Each active clock shifts in the present
// data level as a signed sample; inactive or reset empties every entry.
// Assumes the data input is already synchronous to the filter clock.
module gfsk_delay_line
    import gfsk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic din,
    output smp_t hist [NTAPS]
);

    // Shift register of samples, cleared when the shaper is idle
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            for (int i = 0; i < NTAPS; i++) hist[i] <= '0;
        end else begin
            hist[0] <= '{vld: 1'b1, neg: ~din};
            for (int i = 1; i < NTAPS; i++) hist[i] <= hist[i-1];
        end
    end

    // R2
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (hist[1] == $past(hist[0])) && (hist[NTAPS-1] == $past(hist[NTAPS-2])));

    // R6
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!hist[0].vld && !hist[NTAPS-1].vld));

endmodule

// File: rtl/gfsk_tap_sum.sv
// Weighted sum of the sample history with the Gaussian table, registered.
// Assumes empty entries contribute nothing and signs are +/-1.
module gfsk_tap_sum
    import gfsk_pkg::*;
#(
    parameter int ACC_W = $clog2(TAP_SUM) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active,
    input  smp_t                    hist [NTAPS],
    output logic signed [ACC_W-1:0] acc
);

    logic signed [ACC_W-1:0] term [NTAPS];
    logic signed [ACC_W-1:0] sum_c;

    for (genvar g = 0; g < NTAPS; g++) begin : g_term
        localparam logic signed [ACC_W-1:0] COEF = ACC_W'(tap_coef(g));
        // Signed product of one sample with its weight
        always_comb begin
            if (!hist[g].vld)     term[g] = '0;
            else if (hist[g].neg) term[g] = -COEF;
            else                  term[g] = COEF;
        end
    end

    // Adder tree over all weighted samples
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < NTAPS; i++) sum_c = sum_c + term[i];
    end

    // Pipeline register of the filtered value
    always_ff @(posedge clk) begin
        if (!rst_n || !active) acc <= '0;
        else                   acc <= sum_c;
    end

    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc) <= TAP_SUM) && (int'(acc) >= -TAP_SUM));

endmodule

// File: rtl/gfsk_scaler.sv
// Deviation scaler: multiplies the filtered value by the code's gain,
// rounds to nearest (ties up) and saturates to the output width.
// Assumes SH >= 1, i.e. full scale below TAP_SUM * 128.
module gfsk_scaler
    import gfsk_pkg::*;
#(
    parameter int ACC_W   = 10,
    parameter int OUT_W   = 12,
    parameter int FS_LOG2 = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active,
    input  logic signed [ACC_W-1:0] acc,
    input  logic [2:0]              code,
    output logic signed [OUT_W-1:0] word
);

    localparam int PROD_W = ACC_W + GAIN_W + 1;
    localparam int SH     = TAP_SUM_LOG2 + GAIN_FRAC - FS_LOG2;
    localparam logic signed [PROD_W-1:0] RND   = PROD_W'(1 << (SH - 1));
    localparam logic signed [PROD_W-1:0] O_MAX = PROD_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] O_MIN = -PROD_W'(1 << (OUT_W - 1));
    localparam int BOUND  = ((TAP_SUM * gain_q7(7)) >> SH) + 1;

    logic [GAIN_W-1:0]       gain;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;

    // Gain lookup from the deviation code
    always_comb begin
        gain = GAIN_W'(gain_q7(int'(code)));
    end

    // Multiply, round and shift down to output scale
    always_comb begin
        prod = PROD_W'(acc) * $signed({{(PROD_W-GAIN_W){1'b0}}, gain});
        rnd  = (prod + RND) >>> SH;
    end

    // Saturating output register
    always_ff @(posedge clk) begin
        if (!rst_n || !active)  word <= '0;
        else if (rnd > O_MAX)   word <= O_MAX[OUT_W-1:0];
        else if (rnd < O_MIN)   word <= O_MIN[OUT_W-1:0];
        else                    word <= rnd[OUT_W-1:0];
    end

    // R5
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(word) <= BOUND) && (int'(word) >= -BOUND));

endmodule

// File: rtl/gfsk_tx_shaper.sv
// Top of the Gaussian FSK transmit shaper: sample history, weighted sum
// and deviation scaler in a two-register pipeline after the history.
// Assumes the clock runs at twelve samples per transmitted bit.
module gfsk_tx_shaper
    import gfsk_pkg::*;
#(
    parameter int OUT_W   = 12,
    parameter int FS_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_bit,
    input  logic             shaper_en,
    input  logic             tx_mode,
    input  logic [2:0]       dev_code,
    output logic [OUT_W-1:0] dev_word
);

    localparam int ACC_W = $clog2(TAP_SUM) + 2;

    logic                    active;
    smp_t                    hist [NTAPS];
    logic signed [ACC_W-1:0] acc;
    logic signed [OUT_W-1:0] word;

    // Shaper runs only when enabled and transmitting
    always_comb active = shaper_en & tx_mode;

    gfsk_delay_line u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .din    (tx_bit),
        .hist   (hist)
    );

    gfsk_tap_sum #(.ACC_W(ACC_W)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .hist   (hist),
        .acc    (acc)
    );

    gfsk_scaler #(.ACC_W(ACC_W), .OUT_W(OUT_W), .FS_LOG2(FS_LOG2)) u_scale (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .acc    (acc),
        .code   (dev_code),
        .word   (word)
    );

    assign dev_word = word;

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (dev_word == '0));

    // R7
    mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shaper_en && !tx_mode) |=> (dev_word == '0));

endmodule

// File: tb/gfsk_tx_shaper_tb.sv
// Directed bench for the Gaussian transmit shaper with a reference model.
module gfsk_tx_shaper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_bit = 1'b0;
    logic        shaper_en = 1'b0;
    logic        tx_mode = 1'b0;
    logic [2:0]  dev_code = 3'd4;
    logic [11:0] dev_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Requirement constants (R2 weights, R4 gains)
    int ctab [12] = '{8, 13, 19, 25, 30, 33, 33, 30, 25, 19, 13, 8};
    int gtab [8]  = '{77, 90, 102, 115, 128, 141, 154, 166};

    // Reference model state
    int hist [12];
    int acc_m = 0;
    int out_m = 0;

    always #2 clk = ~clk;

    gfsk_tx_shaper u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_bit    (tx_bit),
        .shaper_en (shaper_en),
        .tx_mode   (tx_mode),
        .dev_code  (dev_code),
        .dev_word  (dev_word)
    );

    // R5 rounding and clamp
    function automatic int rnd_sat(input int x);
        int r;
        r = (x + 16) >>> 5;
        if (r > 2047)  r = 2047;
        if (r < -2048) r = -2048;
        return r;
    endfunction

    // Reference convolution per R2, R5, R6, R7
    always @(posedge clk) begin
        int s;
        if (!rst_n || !(shaper_en && tx_mode)) begin
            for (int i = 0; i < 12; i++) hist[i] = 0;
            acc_m = 0;
            out_m = 0;
        end else begin
            out_m = rnd_sat(acc_m * gtab[dev_code]);
            s = 0;
            for (int i = 0; i < 12; i++) s += ctab[i] * hist[i];
            acc_m = s;
            for (int i = 11; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = tx_bit ? 1 : -1;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input int exp, input string tag);
        checks++;
        if ($signed(dev_word) !== exp) begin
            errors++;
            $display("FAIL %s: dev_word=%0d expected=%0d at %0t", tag, $signed(dev_word), exp, $time);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; shaper_en = 1'b1; tx_mode = 1'b1; tx_bit = 1'b1;
        repeat (3) step();
        check(0, "R1 reset");
        shaper_en = 1'b0;
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_latency();
        dev_code = 3'd4; tx_bit = 1'b1; shaper_en = 1'b1; tx_mode = 1'b1;
        step(); check(0, "R2 latency e1");
        step(); check(0, "R2 latency e2");
        step(); check(32, "R2 latency e3");
        shaper_en = 1'b0; step();
    endtask

    task automatic t_round();
        dev_code = 3'd1; tx_bit = 1'b1; shaper_en = 1'b1; tx_mode = 1'b1;
        repeat (3) step();
        check(23, "R5 tie up positive");
        shaper_en = 1'b0; step();
        tx_bit = 1'b0; shaper_en = 1'b1;
        repeat (3) step();
        check(-22, "R5 tie up negative");
        shaper_en = 1'b0; step();
    endtask

    task automatic t_steady();
        shaper_en = 1'b1; tx_mode = 1'b1;
        for (int c = 0; c < 8; c++) begin
            dev_code = 3'(c);
            tx_bit = 1'b1; repeat (16) step();
            check(8 * gtab[c], (c == 4) ? "R3 steady ones" : "R4 code ones");
            tx_bit = 1'b0; repeat (16) step();
            check(-8 * gtab[c], (c == 4) ? "R3 steady zeros" : "R4 code zeros");
        end
    endtask

    task automatic t_patterns();
        logic [15:0] lfsr = 16'hACE1;
        shaper_en = 1'b1; tx_mode = 1'b1; dev_code = 3'd6;
        for (int b = 0; b < 12; b++) begin
            tx_bit = b[0];
            for (int k = 0; k < 12; k++) begin step(); check(out_m, "R2 bit alternation"); end
        end
        dev_code = 3'd2;
        for (int k = 0; k < 60; k++) begin
            tx_bit = ~tx_bit; step(); check(out_m, "R2 sample toggle");
        end
        dev_code = 3'd7;
        for (int b = 0; b < 40; b++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tx_bit = lfsr[0];
            for (int k = 0; k < 12; k++) begin step(); check(out_m, "R2 random bits"); end
        end
    endtask

    task automatic t_idle(input bit use_mode);
        string tag;
        tag = use_mode ? "R7" : "R6";
        shaper_en = 1'b1; tx_mode = 1'b1; dev_code = 3'd4; tx_bit = 1'b0;
        repeat (16) step();
        check(-1024, {tag, " before drop"});
        if (use_mode) tx_mode = 1'b0; else shaper_en = 1'b0;
        step(); check(0, {tag, " zero after drop"});
        tx_bit = 1'b1;
        repeat (4) step();
        check(0, {tag, " held zero"});
        shaper_en = 1'b1; tx_mode = 1'b1;
        step(); check(0, {tag, " rebuild e1"});
        step(); check(0, {tag, " rebuild e2"});
        step(); check(32, {tag, " rebuild from empty"});
        step(); check(rnd_sat(21 * 128), {tag, " rebuild e4"});
    endtask

    task automatic t_gain_switch();
        shaper_en = 1'b1; tx_mode = 1'b1; dev_code = 3'd4; tx_bit = 1'b1;
        repeat (16) step();
        check(1024, "R8 before switch");
        dev_code = 3'd7;
        step(); check(1328, "R8 next edge");
        dev_code = 3'd0;
        step(); check(616, "R8 history kept");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_round();
        t_steady();
        t_patterns();
        t_idle(1'b0);
        t_idle(1'b1);
        t_gain_switch();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule